// File: doc/BRIEF.md
# Multiplexed SAR Converter Digital Core

This block is the digital side of an eight-input successive-approximation converter, seen from its serial port. A single chip-select/convert input does two jobs. Its rising edge starts a conversion. While it is low, it frames a serial transfer. During that transfer the previous result leaves MSB first on the data output, and a 7-bit setup word arrives on the data input. The setup word picks the input pairing, the polarity of the next conversion and the sleep request. The analog parts sit outside the block: it only presents a trial code to the DAC, reads a one-bit comparator decision back, and publishes the decoded input selection.

The block also tracks the power state. Where it ends up after a conversion depends on the level of the chip-select/convert input at that moment: if the input is still high the core naps, and if the host has already pulled it low the core stays awake and drives the new MSB at once. A committed word with the sleep bit set parks the core, and no conversions start until a later word clears the bit. All inputs are taken to be synchronous to `clk`. Serial clock edges are found by comparing each sample with the one before it.

Top module: `sar_adc_core`

## Requirements
- R1: A conversion starts when a rising edge of `csConv` is sampled while the core is idle and not asleep. `convBusy` is then high for exactly OVERHEAD+WIDTH cycles, and further `csConv` edges during that time neither restart nor stretch the conversion.
- R2: The search decides bits from MSB to LSB, one per cycle, after the OVERHEAD cycles. In each decision cycle, `dacTrial` shows the bits kept so far with the current bit set, and the bit is kept when `cmpKeep` is 1. `resultDone` pulses for one cycle, in the first cycle after `convBusy` drops, when the result latch is updated.
- R3: The setup word is 7 bits, sent first to last as: single-ended flag, odd/sign, address high, address low, common flag, unipolar flag, sleep flag. Single-ended (flag 1): `muxPos`={odd,addrHi,addrLo}, and the negative input is input 7 when the common flag is 1 (`muxNeg`=7, `muxNegGnd`=0) and ground otherwise (`muxNeg`=0, `muxNegGnd`=1). Differential (flag 0): `muxPos`={addrHi,addrLo,odd}, `muxNeg`={addrHi,addrLo,~odd}, `muxNegGnd`=0.
- R4: A setup word is committed on the 7th rising `sck` edge of a frame. A frame with fewer than 7 edges leaves the selection, polarity and power state unchanged, and edges after the 7th are ignored.
- R5: `sdi` is sampled on rising `sck` edges while `csConv` is low. The output word is loaded when `csConv` falls with the core idle, so `sdo` then shows the result MSB. Each falling `sck` edge moves the next lower bit to `sdo`.
- R6: `sdoOe` is 1 exactly while `csConv` is low, and `sdo` is 0 while `sdoOe` is 0.
- R7: If `csConv` is low when a conversion completes, the new result's MSB appears on `sdo` in the cycle of the `resultDone` pulse, and `pwrState` is active (0).
- R8: If `csConv` is high when a conversion completes, `pwrState` becomes nap (1). A falling `csConv` or a conversion start returns it to active (0).
- R9: Committing a word with the sleep flag at 1 sets `pwrState` to sleep (2), and rising `csConv` edges then start no conversion. Committing a word with the sleep flag at 0 returns `pwrState` to active (0).
- R10: With the unipolar flag at 1 the result is straight binary (the searched code). With the flag at 0 the result is two's complement (searched code with the MSB inverted). The flag used is the one committed when the conversion started.
- R11: After reset the core is idle and active, the result latch is 0, and all setup fields are 0: differential, `muxPos`=0, `muxNeg`=1, bipolar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| csConv | input | 1 | Conversion start (rising edge) and serial frame (low) |
| sck | input | 1 | Serial shift clock, oversampled by clk |
| sdi | input | 1 | Serial setup word input |
| cmpKeep | input | 1 | Comparator decision: 1 keeps the trial bit |
| sdo | output | 1 | Serial result output |
| sdoOe | output | 1 | Output enable for sdo (pad tri-state control) |
| dacTrial | output | WIDTH | Code presented to the DAC |
| convBusy | output | 1 | Conversion in progress |
| resultDone | output | 1 | One-cycle pulse when the result latch updates |
| pwrState | output | 2 | 0 active, 1 nap, 2 sleep |
| muxPos | output | 3 | Positive input selection |
| muxNeg | output | 3 | Negative input selection |
| muxNegGnd | output | 1 | Negative input is ground |
| uniMode | output | 1 | Committed polarity, 1 unipolar |

## Verification
The bench builds the core with WIDTH=12 and OVERHEAD=2, so a conversion takes 14 cycles. A full read-out frame is then short enough to run many frame/conversion rounds, including frames that cross a conversion. The narrow word lets the bench hit the all-ones and MSB-only codes in both polarities. It also makes it easy to read back partial frames, where only the top nibble leaves the core, and over-long frames, where extra edges must be ignored. A behavioural model checks busy, done, power state, output enable, serial data and selection against the design on every clock.

// File: rtl/sar_core_pkg.sv
package sar_core_pkg;

  localparam int CFG_BITS   = 7;
  localparam int CFG_FIELDS = CFG_BITS - 1;

  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_NAP    = 2'd1,
    PWR_SLEEP  = 2'd2
  } pwr_e;

  typedef struct packed {
    logic convStart;
    logic bitStep;
    logic convDone;
    logic cfgShift;
    logic cfgCommit;
    logic outLoad;
    logic outShift;
  } strobe_t;

  // first serial bit lands in the top field
  typedef struct packed {
    logic       single;
    logic       oddSign;
    logic [1:0] addr;
    logic       comSel;
    logic       unipolar;
  } cfg_t;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_core_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int OVERHEAD = 3,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csConv,
  input  logic             sck,
  input  logic             sdi,
  output strobe_t          stb,
  output logic [IDX_W-1:0] bitIdx,
  output logic             busy,
  output logic             done,
  output pwr_e             pwr
);

  localparam int TOTAL   = OVERHEAD + WIDTH;
  localparam int CNT_W   = $clog2(TOTAL);
  localparam int FCNT_W  = $clog2(CFG_BITS + 1);

  logic              csPrev, sckPrev;
  logic              busyQ, doneQ;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  stepNum;
  logic [FCNT_W-1:0] bitCnt;
  pwr_e              pwrQ, pwrNext;
  logic              csRise, csFall, sckRise, sckFall, lastStep;

  assign csRise   = csConv & ~csPrev;
  assign csFall   = ~csConv & csPrev;
  assign sckRise  = sck & ~sckPrev & ~csConv;
  assign sckFall  = ~sck & sckPrev & ~csConv;
  assign lastStep = busyQ && (cnt == CNT_W'(TOTAL - 1));

  assign stepNum = cnt - CNT_W'(OVERHEAD);
  assign bitIdx  = IDX_W'(CNT_W'(WIDTH - 1) - stepNum);

  always_comb begin
    stb.convStart = csRise && !busyQ && (pwrQ != PWR_SLEEP);
    stb.bitStep   = busyQ && (cnt >= CNT_W'(OVERHEAD));
    stb.convDone  = lastStep;
    stb.cfgShift  = sckRise && (bitCnt < FCNT_W'(CFG_FIELDS));
    stb.cfgCommit = sckRise && (bitCnt == FCNT_W'(CFG_FIELDS));
    stb.outLoad   = (csFall && !busyQ) || (lastStep && !csConv);
    stb.outShift  = sckFall && !stb.outLoad;
  end

  always_comb begin
    pwrNext = pwrQ;
    if (stb.cfgCommit)
      pwrNext = sdi ? PWR_SLEEP : PWR_ACTIVE;
    else if (lastStep && pwrQ != PWR_SLEEP)
      pwrNext = csConv ? PWR_NAP : PWR_ACTIVE;
    else if (pwrQ == PWR_NAP && (csFall || stb.convStart))
      pwrNext = PWR_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev  <= 1'b1;
      sckPrev <= 1'b0;
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      cnt     <= '0;
      bitCnt  <= '0;
      pwrQ    <= PWR_ACTIVE;
    end else begin
      csPrev  <= csConv;
      sckPrev <= sck;
      doneQ   <= lastStep;
      pwrQ    <= pwrNext;
      if (stb.convStart) begin
        busyQ <= 1'b1;
        cnt   <= '0;
      end else if (busyQ) begin
        if (lastStep) busyQ <= 1'b0;
        else          cnt   <= cnt + 1'b1;
      end
      if (csFall)
        bitCnt <= '0;
      else if (sckRise && bitCnt != FCNT_W'(CFG_BITS))
        bitCnt <= bitCnt + 1'b1;
    end
  end

  assign busy = busyQ;
  assign done = doneQ;
  assign pwr  = pwrQ;

endmodule

// File: rtl/sar_dpath.sv
module sar_dpath
  import sar_core_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic             sdi,
  input  logic             cmpKeep,
  output logic [WIDTH-1:0] dacTrial,
  output logic             sdoBit,
  output logic [2:0]       muxPos,
  output logic [2:0]       muxNeg,
  output logic             muxNegGnd,
  output logic             uniMode
);

  localparam logic [WIDTH-1:0] MSB_MASK = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0]      sarQ, resQ, outQ;
  logic [WIDTH-1:0]      bitMask, trial, sarNext, resNext;
  logic                  uniConv;
  logic [CFG_FIELDS-1:0] cfgSh;
  cfg_t                  cfgQ;

  assign bitMask  = ONE << bitIdx;
  assign trial    = sarQ | bitMask;
  assign sarNext  = (stb.bitStep && cmpKeep) ? trial : sarQ;
  assign resNext  = uniConv ? sarNext : (sarNext ^ MSB_MASK);
  assign dacTrial = stb.bitStep ? trial : sarQ;
  assign sdoBit   = outQ[WIDTH-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sarQ    <= '0;
      resQ    <= '0;
      outQ    <= '0;
      uniConv <= 1'b0;
      cfgSh   <= '0;
      cfgQ    <= '0;
    end else begin
      if (stb.convStart) begin
        sarQ    <= '0;
        uniConv <= cfgQ.unipolar;
      end else if (stb.bitStep) begin
        sarQ <= sarNext;
      end
      if (stb.convDone) resQ <= resNext;
      if (stb.cfgShift)  cfgSh <= {cfgSh[CFG_FIELDS-2:0], sdi};
      if (stb.cfgCommit) cfgQ  <= cfg_t'(cfgSh);
      if (stb.outLoad)
        outQ <= stb.convDone ? resNext : resQ;
      else if (stb.outShift)
        outQ <= {outQ[WIDTH-2:0], 1'b0};
    end
  end

  always_comb begin
    if (cfgQ.single) begin
      muxPos    = {cfgQ.oddSign, cfgQ.addr};
      muxNeg    = cfgQ.comSel ? 3'd7 : 3'd0;
      muxNegGnd = ~cfgQ.comSel;
    end else begin
      muxPos    = {cfgQ.addr, cfgQ.oddSign};
      muxNeg    = {cfgQ.addr, ~cfgQ.oddSign};
      muxNegGnd = 1'b0;
    end
    uniMode = cfgQ.unipolar;
  end

endmodule

// File: rtl/sar_adc_core.sv
module sar_adc_core
  import sar_core_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int OVERHEAD = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csConv,
  input  logic             sck,
  input  logic             sdi,
  input  logic             cmpKeep,
  output logic             sdo,
  output logic             sdoOe,
  output logic [WIDTH-1:0] dacTrial,
  output logic             convBusy,
  output logic             resultDone,
  output logic [1:0]       pwrState,
  output logic [2:0]       muxPos,
  output logic [2:0]       muxNeg,
  output logic             muxNegGnd,
  output logic             uniMode
);

  localparam int IDX_W = $clog2(WIDTH);

  strobe_t          stb;
  logic [IDX_W-1:0] bitIdx;
  logic             sdoBit;
  pwr_e             pwr;

  sar_ctrl #(.WIDTH(WIDTH), .OVERHEAD(OVERHEAD), .IDX_W(IDX_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csConv (csConv),
    .sck    (sck),
    .sdi    (sdi),
    .stb    (stb),
    .bitIdx (bitIdx),
    .busy   (convBusy),
    .done   (resultDone),
    .pwr    (pwr)
  );

  sar_dpath #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .bitIdx    (bitIdx),
    .sdi       (sdi),
    .cmpKeep   (cmpKeep),
    .dacTrial  (dacTrial),
    .sdoBit    (sdoBit),
    .muxPos    (muxPos),
    .muxNeg    (muxNeg),
    .muxNegGnd (muxNegGnd),
    .uniMode   (uniMode)
  );

  assign sdoOe    = ~csConv;
  assign sdo      = sdoOe & sdoBit;
  assign pwrState = pwr;

endmodule

// File: rtl/sar_adc_core_chk.sv
module sar_adc_core_chk #(
  parameter int WIDTH    = 16,
  parameter int OVERHEAD = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             csConv,
  input logic [WIDTH-1:0] dacTrial,
  input logic             convBusy,
  input logic             resultDone,
  input logic [1:0]       pwrState,
  input logic [2:0]       muxPos,
  input logic [2:0]       muxNeg,
  input logic             muxNegGnd,
  input logic             uniMode
);

  localparam int TOTAL = OVERHEAD + WIDTH;

  int unsigned busyLen;

  always_ff @(posedge clk) begin
    if (!rstN)         busyLen <= 0;
    else if (convBusy) busyLen <= busyLen + 1;
    else               busyLen <= 0;
  end

  p_conv_length_r1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convBusy) |-> busyLen == TOTAL);

  p_idle_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(csConv) && !convBusy && pwrState != 2'd2) |=> convBusy);

  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    resultDone |-> (!convBusy && $past(convBusy)));

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    resultDone |=> !resultDone);

  p_dac_idle_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!convBusy && !$past(convBusy)) |-> $stable(dacTrial));

  p_sel_framed_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({muxPos, muxNeg, muxNegGnd, uniMode}) |-> !$past(csConv));

  p_awake_when_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resultDone && !$past(csConv) && pwrState != 2'd2) |-> pwrState == 2'd0);

  p_nap_when_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (resultDone && $past(csConv) && $past(pwrState) != 2'd2) |-> pwrState == 2'd1);

  p_busy_not_nap_r8: assert property (@(posedge clk) disable iff (!rstN)
    convBusy |-> pwrState != 2'd1);

  p_sleep_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd2 && $rose(csConv) && !convBusy) |=> !convBusy);

  p_pwr_legal_r9: assert property (@(posedge clk) disable iff (!rstN)
    pwrState != 2'd3);

endmodule

bind sar_adc_core sar_adc_core_chk #(.WIDTH(WIDTH), .OVERHEAD(OVERHEAD)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .csConv     (csConv),
  .dacTrial   (dacTrial),
  .convBusy   (convBusy),
  .resultDone (resultDone),
  .pwrState   (pwrState),
  .muxPos     (muxPos),
  .muxNeg     (muxNeg),
  .muxNegGnd  (muxNegGnd),
  .uniMode    (uniMode)
);

// File: tb/sim_sar_adc_core.sv
module sim_sar_adc_core;

  localparam int W     = 12;
  localparam int OH    = 2;
  localparam int TOTAL = W + OH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csConv = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic cmpKeep;
  logic sdo, sdoOe, convBusy, resultDone, muxNegGnd, uniMode;
  logic [W-1:0] dacTrial;
  logic [1:0] pwrState;
  logic [2:0] muxPos, muxNeg;
  logic [W-1:0] target = '0;

  int nChk = 0, nErr = 0, cyc = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  assign cmpKeep = (target >= dacTrial);

  sar_adc_core #(.WIDTH(W), .OVERHEAD(OH)) u0 (
    .clk(clk), .rstN(rstN), .csConv(csConv), .sck(sck), .sdi(sdi),
    .cmpKeep(cmpKeep), .sdo(sdo), .sdoOe(sdoOe), .dacTrial(dacTrial),
    .convBusy(convBusy), .resultDone(resultDone), .pwrState(pwrState),
    .muxPos(muxPos), .muxNeg(muxNeg), .muxNegGnd(muxNegGnd), .uniMode(uniMode)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  endtask

  // expected selection from a 6-field setup (SD,OS,A1,A0,COM,UNI)
  function automatic int expPos(bit [5:0] c);
    return c[5] ? {c[4], c[3], c[2]} : {c[3], c[2], c[4]};
  endfunction
  function automatic int expNeg(bit [5:0] c);
    if (c[5]) return c[1] ? 7 : 0;
    return {c[3], c[2], ~c[4]};
  endfunction

  // behavioural reference model
  bit mBusy, mDone, mCsP, mSckP, mUni;
  int mRem, mPwr, mCnt;
  bit [5:0] mCfg, mSh;
  bit [W-1:0] mRes, mOut, mTgt;

  always @(posedge clk) begin
    bit rise, fall, sr, sf, fin, start, load;
    bit [W-1:0] newRes;
    if (!rstN) begin
      mBusy = 0; mDone = 0; mCsP = 1; mSckP = 0; mUni = 0; mRem = 0;
      mPwr = 0; mCnt = 0; mCfg = 0; mSh = 0; mRes = 0; mOut = 0; mTgt = 0;
    end else begin
      rise   = csConv && !mCsP;
      fall   = !csConv && mCsP;
      sr     = sck && !mSckP && !csConv;
      sf     = !sck && mSckP && !csConv;
      fin    = mBusy && (mRem == 1);
      newRes = mUni ? mTgt : (mTgt ^ (W'(1) << (W - 1)));
      start  = rise && !mBusy && (mPwr != 2);
      load   = (fall && !mBusy) || (fin && !csConv);
      if (sr && mCnt == 6) mPwr = sdi ? 2 : 0;
      else if (fin && mPwr != 2) mPwr = csConv ? 1 : 0;
      else if (mPwr == 1 && (fall || start)) mPwr = 0;
      if (fall) mCnt = 0;
      else if (sr && mCnt < 7) begin
        if (mCnt < 6) mSh = {mSh[4:0], sdi};
        else mCfg = mSh;
        mCnt++;
      end
      if (load) mOut = fin ? newRes : mRes;
      else if (sf) mOut = mOut << 1;
      if (fin) mRes = newRes;
      mDone = fin;
      if (start) begin
        mBusy = 1; mRem = TOTAL; mUni = mCfg[0]; mTgt = target;
      end else if (mBusy) begin
        if (mRem == 1) mBusy = 0;
        else mRem--;
      end
      mCsP = csConv; mSckP = sck;
    end
  end

  // per-clock comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rstN && !ended) begin
      chk("R1", "convBusy", convBusy, mBusy);
      chk("R2", "resultDone", resultDone, mDone);
      chk("R8", "pwrState", pwrState, mPwr);
      chk("R6", "sdoOe", sdoOe, !csConv);
      if (!csConv) chk("R5", "sdo", sdo, mOut[W-1]);
      else         chk("R6", "sdo idle", sdo, 0);
      chk("R3", "muxPos", muxPos, expPos(mCfg));
      chk("R3", "muxNeg", muxNeg, expNeg(mCfg));
      chk("R3", "muxNegGnd", muxNegGnd, mCfg[5] && !mCfg[1]);
      chk("R10", "uniMode", uniMode, mCfg[0]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !ended) begin
      nChk++; nErr++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [6:0] w, input int nClk, output logic [W-1:0] got);
    got = '0;
    if (csConv) begin
      @(negedge clk); csConv = 1'b0;
    end
    waitClk(2);
    for (int i = 0; i < nClk; i++) begin
      sdi = (i < 7) ? w[6-i] : 1'b0;
      waitClk(2);
      sck = 1'b1;
      waitClk(2);
      if (i < W) got[W-1-i] = sdo;
      sck = 1'b0;
      waitClk(2);
    end
    @(negedge clk); csConv = 1'b1;
  endtask

  localparam logic [6:0] WA  = 7'b1101010;
  localparam logic [6:0] WB  = 7'b0110000;
  localparam logic [6:0] WC  = 7'b1011110;
  localparam logic [6:0] WCS = 7'b1011111;

  initial begin
    logic [W-1:0] got;
    waitClk(3);
    rstN = 1'b1;
    waitClk(1);
    // R11 reset state
    chk("R11", "pwrState", pwrState, 0);
    chk("R11", "convBusy", convBusy, 0);
    chk("R11", "sdoOe", sdoOe, 0);
    chk("R11", "muxPos", muxPos, 0);
    chk("R11", "muxNeg", muxNeg, 1);
    chk("R11", "uniMode", uniMode, 0);

    // frame 1: read reset result, set single-ended input 5, unipolar
    target = 12'hA5C;
    frame(WA, W, got);
    chk("R11", "first read", got, 0);
    chk("R3", "muxPos single", muxPos, 5);
    chk("R3", "muxNegGnd single", muxNegGnd, 1);
    waitClk(TOTAL + 6);
    chk("R8", "nap after conversion", pwrState, 1);

    // frame 2: read unipolar result, set differential bipolar
    frame(WB, W, got);
    chk("R10", "unipolar result", got, 12'hA5C);
    chk("R5", "msb-first word", got, 12'hA5C);
    chk("R3", "diff muxPos", muxPos, 5);
    chk("R3", "diff muxNeg", muxNeg, 4);
    target = 12'h300;
    // R1: extra edges while busy are ignored
    waitClk(3);
    csConv = 1'b0;
    waitClk(2);
    csConv = 1'b1;
    waitClk(TOTAL + 6);
    chk("R1", "busy after ignored edge", convBusy, 0);
    chk("R8", "nap again", pwrState, 1);

    // frame 3: read bipolar result, set common-input single-ended unipolar
    frame(WC, W, got);
    chk("R10", "bipolar result", got, 12'hB00);
    chk("R2", "search result", got, 12'hB00);
    chk("R3", "com muxNeg", muxNeg, 7);
    target = 12'h800;
    @(negedge clk); csConv = 1'b0;
    waitClk(TOTAL + 4);
    chk("R7", "msb at once", sdo, 1);
    chk("R7", "stays active", pwrState, 0);

    // frame 4 (already low): read, request sleep
    frame(WCS, W, got);
    chk("R7", "result while low", got, 12'h800);
    chk("R9", "sleep entered", pwrState, 2);
    waitClk(4);
    chk("R9", "no conversion in sleep", convBusy, 0);

    // frame 5: partial word
    frame(WA, 4, got);
    chk("R4", "partial read nibble", got[W-1:W-4], 4'h8);
    chk("R4", "selection kept", muxPos, 3);
    chk("R4", "still asleep", pwrState, 2);
    waitClk(4);
    chk("R9", "still idle", convBusy, 0);

    // frame 6: wake, differential bipolar, top code
    target = 12'h7FF;
    frame(WB, W, got);
    chk("R9", "read in sleep", got, 12'h800);
    chk("R9", "woken", pwrState == 2 ? 0 : 1, 1);
    waitClk(TOTAL + 6);

    // frame 7: over-long frame
    frame(WA, W + 2, got);
    chk("R10", "bipolar minus one", got, 12'hFFF);
    chk("R4", "extra edges ignored", muxPos, 5);
    chk("R4", "extra edges uni", uniMode, 1);
    waitClk(TOTAL + 6);
    finishRun();
  end

endmodule